// File: doc/BRIEF.md
# Two-level page table walker

This block resolves a virtual-to-physical translation after a TLB miss by walking a two-level table in memory. A request carries a 32-bit virtual address and the kind of access (read or write, user or supervisor). The walker forms the address of a directory entry from the directory base and the upper ten bits of the virtual page number. If that entry is present, the walker forms the address of a table entry from the entry's base and the next ten bits. It then returns either the physical address or a fault with a cause code.

All memory traffic goes through one read/write port. Each request is held until the memory accepts it, and every request, read or write, gets exactly one response pulse before the walker issues another. The walker maintains the accessed and dirty bits in memory. It writes an entry back only when one of those bits actually changes, and it waits for that write to be acknowledged before answering. A directory entry marking a large page is not walked and is reported as an unsupported size.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid` is 0 and `rsp_valid` is 0.
- R2: The directory entry is read at {dir_base, va[31:22], 2'b00}. The table entry is read at {directory entry[31:12], va[21:12], 2'b00}. A successful response gives rsp_paddr = {table entry[31:12], va[11:0]}.
- R3: An entry with bit 0 (present) clear, at either level, ends the walk with rsp_fault=1 and rsp_cause=1. A non-present directory entry causes no table read.
- R4: A present directory entry with bit 7 set ends the walk with rsp_cause=3 after a single memory read, and it is not written back.
- R5: A write needs bit 1 set in both entries. A user access needs bit 2 set in both entries. Any violation gives rsp_cause=2 and leaves the table entry unwritten. A successful walk has rsp_cause=0 and rsp_fault=0.
- R6: Every response, faulting or not, reports the request's virtual address on rsp_vaddr, its write flag on rsp_write and its user flag on rsp_user.
- R7: Bit 5 (accessed) is set in a directory entry that is present and has bit 7 clear. Bit 5 is also set in the table entry of every successful walk, and bit 6 (dirty) is set there on a successful write. An entry is written to memory only if its value changes.
- R8: At most one memory request is outstanding. A request stays stable until it is accepted. A write-back's response arrives before the translation response.
- R9: `rsp_valid` lasts exactly one cycle, and the walker accepts a new request after it.
- R10: Changing `dir_base` changes which directory is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 20 | Page number of the current directory |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 not present, 2 protection, 3 unsupported size |
| rsp_paddr | output | 32 | Physical address |
| rsp_vaddr | output | 32 | Virtual address of the request |
| rsp_write | output | 1 | Write flag of the request |
| rsp_user | output | 1 | User flag of the request |

## Verification
The hardest situation to reach is a walk that writes back at both levels, and then a walk that writes at neither, even though it succeeds. The memory image is built so that the same directory entry starts with its accessed bit clear and is then reused. The stimulus sequence sets accessed and then dirty on one table entry over successive walks. Write and read counts are checked for each walk. A supervisor-only directory entry is first met through a faulting user access, which still has to set its accessed bit. A stalling memory is then combined with a write-back.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [19:0] dir_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [1:0]  rsp_cause,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_vaddr,
  output logic        rsp_write,
  output logic        rsp_user
);
  localparam int B_PRES = 0;
  localparam int B_RW   = 1;
  localparam int B_US   = 2;
  localparam int B_ACC  = 5;
  localparam int B_DIRT = 6;
  localparam int B_SIZE = 7;

  localparam logic [1:0] C_OK   = 2'd0;
  localparam logic [1:0] C_NP   = 2'd1;
  localparam logic [1:0] C_PROT = 2'd2;
  localparam logic [1:0] C_SIZE = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RWAIT, S_WR, S_WWAIT, S_RESP} st_t;

  st_t         st;
  logic        lvl;
  logic [31:0] va;
  logic        wr, us;
  logic [19:0] base, tbl_base;
  logic        dir_rw, dir_us;
  logic [31:0] ent;
  logic [1:0]  cause;
  logic [31:0] paddr;

  logic [31:0] d;
  logic        perm_bad;
  logic [31:0] upd;

  assign d        = mem_rsp_rdata;
  assign perm_bad = (wr && !(dir_rw && d[B_RW])) || (us && !(dir_us && d[B_US]));
  assign upd      = d | (32'd1 << B_ACC) | ({31'd0, wr} << B_DIRT);

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD) || (st == S_WR);
  assign mem_req_write = (st == S_WR);
  assign mem_req_addr  = lvl ? {tbl_base, va[21:12], 2'b00} : {base, va[31:22], 2'b00};
  assign mem_req_wdata = ent;

  assign rsp_valid = (st == S_RESP);
  assign rsp_cause = cause;
  assign rsp_fault = (cause != C_OK);
  assign rsp_paddr = paddr;
  assign rsp_vaddr = va;
  assign rsp_write = wr;
  assign rsp_user  = us;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      lvl      <= 1'b0;
      va       <= '0;
      wr       <= 1'b0;
      us       <= 1'b0;
      base     <= '0;
      tbl_base <= '0;
      dir_rw   <= 1'b0;
      dir_us   <= 1'b0;
      ent      <= '0;
      cause    <= C_OK;
      paddr    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va    <= req_vaddr;
          wr    <= req_write;
          us    <= req_user;
          base  <= dir_base;
          lvl   <= 1'b0;
          cause <= C_OK;
          paddr <= '0;
          st    <= S_RD;
        end
        S_RD: if (mem_req_ready) st <= S_RWAIT;
        S_RWAIT: if (mem_rsp_valid) begin
          if (!lvl) begin
            tbl_base <= d[31:12];
            dir_rw   <= d[B_RW];
            dir_us   <= d[B_US];
            if (!d[B_PRES]) begin
              cause <= C_NP;
              st    <= S_RESP;
            end else if (d[B_SIZE]) begin
              cause <= C_SIZE;
              st    <= S_RESP;
            end else if (!d[B_ACC]) begin
              ent <= d | (32'd1 << B_ACC);
              st  <= S_WR;
            end else begin
              lvl <= 1'b1;
              st  <= S_RD;
            end
          end else begin
            if (!d[B_PRES]) begin
              cause <= C_NP;
              st    <= S_RESP;
            end else if (perm_bad) begin
              cause <= C_PROT;
              st    <= S_RESP;
            end else begin
              paddr <= {d[31:12], va[11:0]};
              if (upd != d) begin
                ent <= upd;
                st  <= S_WR;
              end else begin
                st <= S_RESP;
              end
            end
          end
        end
        S_WR: if (mem_req_ready) st <= S_WWAIT;
        S_WWAIT: if (mem_rsp_valid) begin
          if (!lvl) begin
            lvl <= 1'b1;
            st  <= S_RD;
          end else begin
            st <= S_RESP;
          end
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !rsp_valid);

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == rsp_vaddr[11:0]);

  p_wb_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> mem_req_wdata[B_ACC] && mem_req_wdata[B_PRES]);

  p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  p_one_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_P = 10;
  localparam int NVEC  = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [19:0] dir_base = '0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        rsp_valid, rsp_fault, rsp_write, rsp_user;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr, rsp_vaddr;

  always #(CLK_P/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr),
    .rsp_write(rsp_write), .rsp_user(rsp_user)
  );

  logic [31:0] mem [0:8191];
  logic        stall = 1'b0;
  logic        tog = 1'b0;
  logic        pl_en = 1'b0;
  logic [12:0] pl_idx = '0;
  logic [31:0] pl_dat = '0;
  int          rcnt = 0, wcnt = 0;

  assign mem_req_ready = !stall || tog;

  always @(posedge clk) begin
    tog <= ~tog;
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 8192; i++) mem[i] <= '0;
      mem_rsp_rdata <= '0;
    end else if (pl_en) begin
      mem[pl_idx] <= pl_dat;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        mem[mem_req_addr[14:2]] <= mem_req_wdata;
        wcnt <= wcnt + 1;
      end else begin
        mem_rsp_rdata <= mem[mem_req_addr[14:2]];
        rcnt <= rcnt + 1;
      end
    end
  end

  int errors = 0, checks = 0;
  logic done = 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] addr, input logic [31:0] val);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = addr[14:2]; pl_dat = val;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  logic [1:0]  g_cause;
  logic [31:0] g_paddr, g_vaddr;
  logic        g_write, g_user, g_got;
  int          g_rd, g_wr, g_wr_at_rsp;

  task automatic walk(input logic [31:0] va, input logic w, input logic u);
    int r0, w0, n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r0 = rcnt; w0 = wcnt;
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
    g_got = rsp_valid;
    g_cause = rsp_cause; g_paddr = rsp_paddr; g_vaddr = rsp_vaddr;
    g_write = rsp_write; g_user = rsp_user;
    g_wr_at_rsp = wcnt - w0;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9 single-cycle response", {31'd0, rsp_valid}, 32'd0);
    g_rd = rcnt - r0; g_wr = wcnt - w0;
  endtask

  // {va, write, user, cause, paddr, reads, writes}
  localparam logic [71:0] VEC [NVEC] = '{
    {32'h0000_0123, 1'b0, 1'b1, 2'd0, 32'h0ABC_D123, 2'd2, 2'd2},
    {32'h0000_0456, 1'b1, 1'b1, 2'd0, 32'h0ABC_D456, 2'd2, 2'd1},
    {32'h0000_1000, 1'b0, 1'b0, 2'd1, 32'h0000_0000, 2'd2, 2'd0},
    {32'h0000_2010, 1'b1, 1'b1, 2'd2, 32'h0000_0000, 2'd2, 2'd0},
    {32'h0000_2010, 1'b0, 1'b1, 2'd0, 32'h0005_5010, 2'd2, 2'd1},
    {32'h0000_3ABC, 1'b1, 1'b1, 2'd0, 32'h1234_5ABC, 2'd2, 2'd0},
    {32'h0040_0008, 1'b1, 1'b0, 2'd2, 32'h0000_0000, 2'd2, 2'd0},
    {32'h0040_0008, 1'b0, 1'b1, 2'd0, 32'h0077_7008, 2'd2, 2'd1},
    {32'h0080_0000, 1'b0, 1'b0, 2'd1, 32'h0000_0000, 2'd1, 2'd0},
    {32'h00C0_0000, 1'b0, 1'b0, 2'd3, 32'h0000_0000, 2'd1, 2'd0},
    {32'h0100_0004, 1'b0, 1'b1, 2'd2, 32'h0000_0000, 2'd2, 2'd1},
    {32'h0100_0004, 1'b1, 1'b0, 2'd0, 32'h0088_8004, 2'd2, 2'd1}
  };

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1 reset state",
        {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
    rst_n = 1'b1;
    poke(32'h0000_0000, 32'h0000_1007);
    poke(32'h0000_0004, 32'h0000_2025);
    poke(32'h0000_0008, 32'h0000_0000);
    poke(32'h0000_000C, 32'h0040_0083);
    poke(32'h0000_0010, 32'h0000_3003);
    poke(32'h0000_1000, 32'h0ABC_D007);
    poke(32'h0000_1008, 32'h0005_5005);
    poke(32'h0000_100C, 32'h1234_5067);
    poke(32'h0000_2000, 32'h0077_7007);
    poke(32'h0000_3000, 32'h0088_8007);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1 idle after reset",
        {29'd0, req_ready, mem_req_valid, rsp_valid}, 32'h4);

    for (int k = 0; k < NVEC; k++) begin
      logic [71:0] v;
      v = VEC[k];
      walk(v[71:40], v[39], v[38]);
      chk(g_got, "R9 response seen", {31'd0, g_got}, 32'd1);
      chk(g_cause == v[37:36], "R3 R4 R5 cause", {30'd0, g_cause}, {30'd0, v[37:36]});
      if (v[37:36] == 2'd0)
        chk(g_paddr == v[35:4], "R2 physical address", g_paddr, v[35:4]);
      chk(g_vaddr == v[71:40] && g_write == v[39] && g_user == v[38], "R6 request echo",
          g_vaddr, v[71:40]);
      chk(g_rd == int'(v[3:2]), "R3 R4 read count", g_rd, {30'd0, v[3:2]});
      chk(g_wr == int'(v[1:0]), "R7 write-back count", g_wr, {30'd0, v[1:0]});
      chk(g_wr_at_rsp == int'(v[1:0]), "R8 write done before response", g_wr_at_rsp, {30'd0, v[1:0]});
    end

    chk(mem[0] == 32'h0000_1027, "R7 directory accessed bit", mem[0], 32'h0000_1027);
    chk(mem[1024] == 32'h0ABC_D067, "R7 table accessed and dirty", mem[1024], 32'h0ABC_D067);
    chk(mem[1026] == 32'h0005_5025, "R7 read sets accessed only", mem[1026], 32'h0005_5025);
    chk(mem[4] == 32'h0000_3023, "R7 faulting walk marks directory", mem[4], 32'h0000_3023);
    chk(mem[3] == 32'h0040_0083, "R4 large entry untouched", mem[3], 32'h0040_0083);
    chk(mem[1025] == 32'h0000_0000, "R3 absent entry untouched", mem[1025], 32'h0);

    poke(32'h0000_4000, 32'h0000_2027);
    dir_base = 20'h00004;
    walk(32'h0000_0ABC, 1'b0, 1'b1);
    chk(g_cause == 2'd0 && g_paddr == 32'h0077_7ABC, "R10 directory base selects table",
        g_paddr, 32'h0077_7ABC);
    chk(g_wr == 0, "R7 no change no write", g_wr, 32'd0);
    dir_base = 20'h00000;

    poke(32'h0000_3004, 32'h0099_9007);
    stall = 1'b1;
    walk(32'h0100_1020, 1'b1, 1'b0);
    stall = 1'b0;
    chk(g_cause == 2'd0 && g_paddr == 32'h0099_9020, "R8 stalled memory result",
        g_paddr, 32'h0099_9020);
    chk(g_rd == 2 && g_wr_at_rsp == 1, "R8 stalled write before response",
        g_wr_at_rsp, 32'd1);
    chk(mem[3073] == 32'h0099_9067, "R7 stalled write-back value", mem[3073], 32'h0099_9067);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule